// File: doc/BRIEF.md
# Write-Only SPI Register Port

This block is a serial slave that lets a host load a small bank of configuration registers over three input wires: an active-low select, a serial bit clock and a serial data line. The port has no output data line, so nothing can be read back. Each register's current value is exposed at all times on a wide parallel output bus for the surrounding logic to use.

A frame begins when the host pulls select low. The frame has four parts, sent most significant bit first. The first is a 7-bit device address, which must be 0010000 binary. The second is a direction bit, which must be 0. The third is a pointer byte: bit 7 is a step flag and bits 6:0 are a register index. The last is one or more data bytes. When the step flag is clear, every data byte lands in the same register. When it is set, the index advances by one after each byte. The three serial inputs may toggle with no relation to the system clock. They are brought into the system clock domain through a short synchronizer chain, and bit-clock rising edges are found there.

Top module: `cfg_spi_regport`

## Requirements
- R1: After reset every register of the bank reads 0x00 on `regBank`, where register i occupies bits [8*i+7 : 8*i].
- R2: A frame whose first 7 bits are 0010000 and whose 8th bit is 0, followed by a pointer byte with index i below 16, followed by a data byte, writes that data byte into register i. All fields are sent MSB first and sampled on rising bit-clock edges. No other register changes.
- R3: A frame whose 7-bit device address differs from 0010000 writes nothing. The rest of that frame is ignored until select rises.
- R4: A frame whose direction bit is 1 writes nothing. The rest of that frame is ignored until select rises.
- R5: When pointer bit 7 is 0, every data byte in the frame goes to the same register, so the last complete byte is the one that remains.
- R6: When pointer bit 7 is 1, the index (pointer bits 6:0) advances by one after each data byte. Successive bytes therefore fill consecutive registers.
- R7: A data byte aimed at an index of 16 or more is discarded and changes no register. With stepping enabled, an index that reaches 16 drops every later byte of the frame.
- R8: Select going high at any point ends the frame. A partially received byte is never written, and the next frame starts again from the first address bit.
- R9: While select is high, activity on the bit clock and data lines does not change the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data from the host, MSB first |
| regBank | output | NUM_REGS*8 | All register contents, register i at bits [8*i+7:8*i] |

## Verification
The hardest cases to reach from the ports are the ones where the pointer and the abort logic meet. The first is a stepping burst that runs past the last implemented register, so later bytes must vanish while earlier ones land. The second is a select release a few bits into a data byte that follows a byte already written. The stimulus reaches both by building frames bit by bit with explicit byte counts and partial-byte lengths. A full sweep of all 128 device addresses shows that only one address is accepted. After every frame the bench compares all sixteen registers against a model that applies the frame rules arithmetically.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  // Frame field widths; the pointer layout (flag on top, index below) is fixed
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int PTR_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftBit;   // take the synchronized data bit into the shifter
    logic clearByte;  // drop any partial byte (select inactive)
    logic loadPtr;    // completed byte is the pointer byte
    logic writeByte;  // completed byte is a data byte
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,   // collecting device address and direction bit
    ST_PTR  = 2'd1,   // collecting the pointer byte
    ST_DATA = 2'd2,   // collecting data bytes
    ST_SKIP = 2'd3    // frame rejected, wait for select to rise
  } frameState_t;

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chainQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ[0] <= RST_VAL;
        else       chainQ[0] <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {STAGES{RST_VAL}};
        else       chainQ <= {chainQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chainQ[STAGES-1];

endmodule

// File: rtl/cfg_spi_ctrl.sv
module cfg_spi_ctrl
  import cfg_spi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              bitEdge,
  input  logic [BYTE_W-1:0] byteNow,
  output ctlStrobe_t        strobe
);

  localparam logic [BYTE_W-1:0] HDR_OK = {DEV_ADDR, 1'b0};
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

  frameState_t stateQ, stateD;
  logic [CNT_W-1:0] bitCntQ, bitCntD;
  logic takeBit, byteDone;

  assign takeBit  = csActive && bitEdge;
  assign byteDone = takeBit && (bitCntQ == LAST_BIT);

  always_comb begin
    strobe.clearByte = !csActive;
    strobe.shiftBit  = takeBit && (stateQ != ST_SKIP);
    strobe.loadPtr   = byteDone && (stateQ == ST_PTR);
    strobe.writeByte = byteDone && (stateQ == ST_DATA);
  end

  always_comb begin
    stateD  = stateQ;
    bitCntD = bitCntQ;
    if (!csActive) begin
      stateD  = ST_HDR;
      bitCntD = '0;
    end else if (takeBit) begin
      bitCntD = bitCntQ + 1'b1;
      if (byteDone) begin
        bitCntD = '0;
        unique case (stateQ)
          ST_HDR:  stateD = (byteNow == HDR_OK) ? ST_PTR : ST_SKIP;
          ST_PTR:  stateD = ST_DATA;
          ST_DATA: stateD = ST_DATA;
          ST_SKIP: stateD = ST_SKIP;
          default: stateD = ST_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_HDR;
      bitCntQ <= '0;
    end else begin
      stateQ  <= stateD;
      bitCntQ <= bitCntD;
    end
  end

endmodule

// File: rtl/cfg_spi_dpath.sv
module cfg_spi_dpath
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sdiS,
  input  ctlStrobe_t                       strobe,
  output logic [BYTE_W-1:0]                byteNow,
  output logic [PTR_W-1:0]                 ptrIdx,
  output logic                             incFlag,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  bankQ
);

  logic [BYTE_W-2:0] shiftQ;

  // Completed byte as seen on the edge that brings in its last bit
  assign byteNow = {shiftQ, sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobe.clearByte) begin
      shiftQ <= '0;
    end else if (strobe.shiftBit) begin
      shiftQ <= byteNow[BYTE_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrIdx  <= '0;
      incFlag <= 1'b0;
    end else if (strobe.loadPtr) begin
      incFlag <= byteNow[BYTE_W-1];
      ptrIdx  <= byteNow[PTR_W-1:0];
    end else if (strobe.writeByte && incFlag) begin
      ptrIdx  <= ptrIdx + 1'b1;
    end
  end

  // One register per implemented index; indices with no register match nothing
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [PTR_W-1:0] MY_IDX = PTR_W'(g);
      logic [BYTE_W-1:0] regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regQ <= '0;
        else if (strobe.writeByte && (ptrIdx == MY_IDX))
          regQ <= byteNow;
      end
      assign bankQ[g] = regQ;
    end
  endgenerate

endmodule

// File: rtl/cfg_spi_regport.sv
module cfg_spi_regport
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic [NUM_REGS*BYTE_W-1:0] regBank
);

  logic csS, sclkS, sdiS, sclkDly;
  logic csActive, bitEdge;
  logic [BYTE_W-1:0] byteNow;
  logic [PTR_W-1:0]  ptrIdx;
  logic              incFlag;
  logic [NUM_REGS-1:0][BYTE_W-1:0] bankQ;
  ctlStrobe_t strobe;

  cfg_spi_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sclk, sdi}),
    .dout({csS, sclkS, sdiS})
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkDly <= 1'b0;
    else       sclkDly <= sclkS;
  end

  assign bitEdge  = sclkS && !sclkDly;
  assign csActive = !csS;

  cfg_spi_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .csActive(csActive),
    .bitEdge (bitEdge),
    .byteNow (byteNow),
    .strobe  (strobe)
  );

  cfg_spi_dpath #(.NUM_REGS(NUM_REGS)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .sdiS   (sdiS),
    .strobe (strobe),
    .byteNow(byteNow),
    .ptrIdx (ptrIdx),
    .incFlag(incFlag),
    .bankQ  (bankQ)
  );

  assign regBank = bankQ;

endmodule

// File: rtl/cfg_spi_regport_chk.sv
module cfg_spi_regport_chk
  import cfg_spi_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input logic [NUM_REGS*BYTE_W-1:0] regBank,
  input logic                       writeByte,
  input logic                       incFlag,
  input logic [PTR_W-1:0]           ptrIdx
);

  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(NUM_REGS);

  logic [2:0] quietCnt;
  logic [NUM_REGS*BYTE_W-1:0] prevBank;
  logic [NUM_REGS-1:0] chgMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      prevBank <= '0;
    end else begin
      prevBank <= regBank;
      if (!csN)               quietCnt <= '0;
      else if (quietCnt != 3'd7) quietCnt <= quietCnt + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      chgMask[i] = (regBank[i*BYTE_W +: BYTE_W] != prevBank[i*BYTE_W +: BYTE_W]);
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (regBank == '0));

  // R2
  single_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chgMask) <= 1);

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeByte && !incFlag) |=> $stable(ptrIdx));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeByte && incFlag) |=> (ptrIdx == PTR_W'($past(ptrIdx) + 1'b1)));

  // R7
  drop_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeByte && (ptrIdx >= TOP_IDX)) |=> $stable(regBank));

  // R9
  quiet_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt >= 3'd4) |-> $stable(regBank));

endmodule

bind cfg_spi_regport cfg_spi_regport_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .regBank  (regBank),
  .writeByte(strobe.writeByte),
  .incFlag  (incFlag),
  .ptrIdx   (ptrIdx)
);

// File: tb/cfg_spi_regport_tb.sv
`timescale 1ns/1ps
module cfg_spi_regport_tb_top;

  localparam int NREG = 16;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [NREG*8-1:0] regBank;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] expBank [NREG];
  logic [7:0] dataBuf [8];

  always #2 clk = ~clk;   // 250 MHz

  cfg_spi_regport #(.NUM_REGS(NREG)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .regBank(regBank)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdi = b;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
    sclk = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) sendBit(v[i]);
  endtask

  task automatic frameOpen();
    waitClk(2);
    csN = 1'b0;
    waitClk(4);
  endtask

  task automatic frameClose();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(12);
  endtask

  // Model of R2-R7: header check, pointer flag, index step, drop above bank
  task automatic model(input logic [6:0] addr, input logic dir,
                       input logic [7:0] ptr, input int n);
    logic [6:0] idx;
    if (addr != 7'b0010000 || dir) return;
    idx = ptr[6:0];
    for (int k = 0; k < n; k++) begin
      if (idx < NREG) expBank[idx] = dataBuf[k];
      if (ptr[7]) idx = idx + 7'd1;
    end
  endtask

  task automatic sendFrame(input logic [6:0] addr, input logic dir,
                           input logic [7:0] ptr, input int n);
    frameOpen();
    sendBits({addr, dir}, 8);
    sendBits(ptr, 8);
    for (int k = 0; k < n; k++) sendBits(dataBuf[k], 8);
    frameClose();
    model(addr, dir, ptr, n);
  endtask

  task automatic checkBank(input string tag);
    for (int i = 0; i < NREG; i++) begin
      vectors++;
      if (regBank[i*8 +: 8] !== expBank[i]) begin
        miscompares++;
        $display("FAIL %s reg %0d actual=%h expected=%h", tag, i, regBank[i*8 +: 8], expBank[i]);
      end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) expBank[i] = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    checkBank("R1");

    // R3 / R2: every device address, only 0010000 accepted
    for (int a = 0; a < 128; a++) begin
      dataBuf[0] = 8'((a * 3 + 1) & 8'hFF);
      sendFrame(7'(a), 1'b0, {1'b0, 3'b000, 4'(a)}, 1);
      checkBank((a == 16) ? "R2" : "R3");
    end

    // R4: read direction rejected, then a valid write recovers
    dataBuf[0] = 8'hEE;
    sendFrame(7'b0010000, 1'b1, 8'h05, 1);
    checkBank("R4");
    dataBuf[0] = 8'h3C;
    sendFrame(7'b0010000, 1'b0, 8'h05, 1);
    checkBank("R4");

    // R2: each register individually
    for (int i = 0; i < NREG; i++) begin
      dataBuf[0] = 8'((i * 37 + 11) & 8'hFF);
      sendFrame(7'b0010000, 1'b0, 8'(i), 1);
      checkBank("R2");
    end

    // R5: fixed pointer burst, last byte remains
    dataBuf[0] = 8'h11; dataBuf[1] = 8'h22; dataBuf[2] = 8'h33; dataBuf[3] = 8'hA4;
    sendFrame(7'b0010000, 1'b0, 8'h03, 4);
    checkBank("R5");

    // R6: stepping burst over consecutive registers
    for (int k = 0; k < 6; k++) dataBuf[k] = 8'(8'hC0 + k * 5);
    sendFrame(7'b0010000, 1'b0, 8'h82, 6);
    checkBank("R6");

    // R7: out-of-range index, stepping across the top, start beyond the bank
    dataBuf[0] = 8'h99;
    sendFrame(7'b0010000, 1'b0, 8'h14, 1);
    checkBank("R7");
    dataBuf[0] = 8'h5A; dataBuf[1] = 8'hA5; dataBuf[2] = 8'h77; dataBuf[3] = 8'h88;
    sendFrame(7'b0010000, 1'b0, 8'h8E, 4);
    checkBank("R7");
    sendFrame(7'b0010000, 1'b0, 8'h90, 3);
    checkBank("R7");

    // R8: abort five bits into the first data byte
    frameOpen();
    sendBits({7'b0010000, 1'b0}, 8);
    sendBits(8'h04, 8);
    sendBits(8'hFF, 5);
    frameClose();
    checkBank("R8");

    // R8: abort in the pointer, then a full frame starts clean
    frameOpen();
    sendBits({7'b0010000, 1'b0}, 8);
    sendBits(8'h06, 3);
    frameClose();
    checkBank("R8");
    dataBuf[0] = 8'h6D;
    sendFrame(7'b0010000, 1'b0, 8'h06, 1);
    checkBank("R8");

    // R8: first byte of a stepping burst lands, trailing partial byte does not
    frameOpen();
    sendBits({7'b0010000, 1'b0}, 8);
    sendBits(8'h89, 8);
    sendBits(8'h42, 8);
    sendBits(8'hFF, 3);
    frameClose();
    expBank[9] = 8'h42;
    checkBank("R8");

    // R9: bit clock and data toggling with select high
    for (int k = 0; k < 24; k++) sendBit(1'(k & 1));
    waitClk(8);
    checkBank("R9");

    summary();
    $finish;
  end

endmodule